// File: doc/BRIEF.md
# Posted Column-Command Latency Pipeline

This block sits between a DRAM command decoder and the data path. It accepts READ and WRITE column commands as soon as the controller issues them. It holds each command for a programmable posted delay (the additive latency, AL) and then releases it as an internal column command. The block also produces two per-clock windows. The read window marks the clocks in which read data must be on the data path. The write window marks the clocks in which write data is expected. Each window carries the tag of the command that owns the data in that clock.

The read latency is the sum of the posted delay and the CAS latency (CL). The write latency is one clock less than the read latency. A burst of four data elements occupies two clocks, and a burst of eight occupies four clocks, because two elements move per clock. When bursts run back to back, the window has no gaps. When a later read truncates an eight-element read, the later read takes over the window. A latency setting that uses a reserved code is refused and reported. A setting written while commands are still in flight is ignored.

Top module: `cas_post_pipe`

## Requirements
- R1: After reset all outputs are low, the posted delay is 0 and the CAS latency is 3.
- R2: A command accepted in clock k (cmd_vld high) appears on icmd_vld in clock k+AL with the same type, burst size and tag. With AL=0 it appears in clock k itself.
- R3: A read accepted in clock k drives rd_win high, with rd_tag equal to its tag, from clock k+AL+CL. The window lasts 2 clocks when cmd_bl8=0 and 4 clocks when cmd_bl8=1.
- R4: A write (cmd_wr=1) accepted in clock k drives wr_win high, with wr_tag equal to its tag, from clock k+AL+CL-1. The window lasts for the same burst clocks as in R3.
- R5: Commands of one type spaced exactly their burst clocks apart (2 clocks for bl8=0, 4 clocks for bl8=1) produce a window with no gap. The tag switches at the burst boundary.
- R6: When an eight-element read is followed two clocks later by another read, the first read keeps the window for only 2 clocks. The second read owns the window from the next clock.
- R7: A setting write with an AL code of 7, or a CL code below 2, raises cfg_err for exactly the next clock. The previous AL and CL stay in force.
- R8: A setting write made while cmd_vld is high, or within 16 clocks after the last accepted command (default parameters), is ignored. Later commands use the previous latencies.
- R9: A legal setting write made while idle takes effect for the next command and leaves cfg_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Column command issued this clock |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_bl8 | input | 1 | 1 = eight-element burst, 0 = four-element burst |
| cmd_tag | input | TAG_W | Bank/column tag of the command |
| cfg_we | input | 1 | Write the latency settings |
| cfg_al | input | AL_W | Posted delay code in clocks (0..6 legal) |
| cfg_cl | input | CL_W | CAS latency code in clocks (2..7 legal) |
| icmd_vld | output | 1 | Internal column command released |
| icmd_wr | output | 1 | Type of the released command |
| icmd_bl8 | output | 1 | Burst size of the released command |
| icmd_tag | output | TAG_W | Tag of the released command |
| rd_win | output | 1 | Read data due this clock |
| rd_tag | output | TAG_W | Tag owning the read data |
| wr_win | output | 1 | Write data expected this clock |
| wr_tag | output | TAG_W | Tag owning the write data |
| cfg_err | output | 1 | Reserved latency code was refused |

## Verification
The bench aims at the edges of the latency arithmetic:
- AL=0, where the internal command must pass through in the same clock. A design that registers it arrives one clock late.
- The largest setting, AL=6 with CL=7, where the window reaches the deepest pipeline stage. A pipeline that is too short drops the tail of the burst.
- The smallest write latency of one clock, which catches an off-by-one between the read and write taps.

Seamless bursts and a truncated eight-element read test the window ownership: a design that merged overlapping bursts wrongly would show a gap, a stale tag or an overlong burst. Reserved codes and setting writes made while a command is in flight must leave the latencies unchanged, and the bench proves this from the timing of the next read.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  typedef enum logic {
    KIND_RD = 1'b0,
    KIND_WR = 1'b1
  } kind_e;

  // clocks occupied by one burst on a double-rate data path
  function automatic int unsigned burst_clocks(logic bl8);
    return bl8 ? 32'd4 : 32'd2;
  endfunction

  function automatic logic code_reserved(int unsigned al, int unsigned cl,
                                         int unsigned al_max, int unsigned cl_min);
    return (al > al_max) || (cl < cl_min);
  endfunction

endpackage

// File: rtl/cpp_cfg.sv
module cpp_cfg #(
  parameter int unsigned AL_W   = 3,
  parameter int unsigned CL_W   = 3,
  parameter int unsigned AL_MAX = 6,
  parameter int unsigned CL_MIN = 2,
  parameter int unsigned AL_RST = 0,
  parameter int unsigned CL_RST = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AL_W-1:0] cfg_al,
  input  logic [CL_W-1:0] cfg_cl,
  input  logic            idle,
  output logic [AL_W-1:0] al_q,
  output logic [CL_W-1:0] cl_q,
  output logic            err_q
);

  logic            bad;
  logic            take;
  logic [AL_W-1:0] al_d;
  logic [CL_W-1:0] cl_d;
  logic            err_d;

  always_comb begin
    bad   = cpp_pkg::code_reserved(32'(cfg_al), 32'(cfg_cl), AL_MAX, CL_MIN);
    take  = cfg_we && !bad && idle;
    al_d  = take ? cfg_al : al_q;
    cl_d  = take ? cfg_cl : cl_q;
    err_d = cfg_we && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q  <= AL_W'(AL_RST);
      cl_q  <= CL_W'(CL_RST);
      err_q <= 1'b0;
    end else begin
      al_q  <= al_d;
      cl_q  <= cl_d;
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/cpp_delay.sv
module cpp_delay #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_wr,
  input  logic             in_bl8,
  input  logic [TAG_W-1:0] in_tag,
  output logic [DEPTH:0]   t_vld,
  output logic [DEPTH:0]   t_wr,
  output logic [DEPTH:0]   t_bl8,
  output logic [TAG_W-1:0] t_tag [0:DEPTH],
  output logic             busy
);

  // stage i holds the command accepted i+1 clocks ago
  logic [DEPTH-1:0] r_vld;
  logic [DEPTH-1:0] n_vld;
  logic [DEPTH-1:0] r_wr;
  logic [DEPTH-1:0] r_bl8;
  logic [TAG_W-1:0] r_tag [DEPTH];

  always_comb begin
    n_vld = {r_vld[DEPTH-2:0], in_vld};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_vld <= '0;
    else        r_vld <= n_vld;
  end

  // payload stages load only when the stage behind them carries a command
  always_ff @(posedge clk) begin
    if (in_vld) begin
      r_wr[0]  <= in_wr;
      r_bl8[0] <= in_bl8;
      r_tag[0] <= in_tag;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (r_vld[i-1]) begin
        r_wr[i]  <= r_wr[i-1];
        r_bl8[i] <= r_bl8[i-1];
        r_tag[i] <= r_tag[i-1];
      end
    end
  end

  assign t_vld    = {r_vld, in_vld};
  assign t_wr     = {r_wr, in_wr};
  assign t_bl8    = {r_bl8, in_bl8};
  assign t_tag[0] = in_tag;
  for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
    assign t_tag[i] = r_tag[i-1];
  end

  assign busy = |r_vld;

endmodule

// File: rtl/cpp_win.sv
module cpp_win #(
  parameter int unsigned   TAG_W = 6,
  parameter int unsigned   DEPTH = 16,
  parameter int unsigned   IDX_W = 5,
  parameter cpp_pkg::kind_e KIND = cpp_pkg::KIND_RD
) (
  input  logic [DEPTH:0]   t_vld,
  input  logic [DEPTH:0]   t_wr,
  input  logic [DEPTH:0]   t_bl8,
  input  logic [TAG_W-1:0] t_tag [0:DEPTH],
  input  logic [IDX_W-1:0] base,
  output logic             win,
  output logic [TAG_W-1:0] tag
);

  localparam int unsigned SPAN = 4;

  logic [IDX_W:0] idx;

  // scan from the oldest start to the newest so the newest covering burst wins
  always_comb begin
    win = 1'b0;
    tag = '0;
    idx = '0;
    for (int o = SPAN - 1; o >= 0; o--) begin
      idx = {1'b0, base} + (IDX_W+1)'(o);
      if (32'(idx) <= DEPTH) begin
        if (t_vld[idx[IDX_W-1:0]] && (t_wr[idx[IDX_W-1:0]] == KIND) &&
            (32'(o) < cpp_pkg::burst_clocks(t_bl8[idx[IDX_W-1:0]]))) begin
          win = 1'b1;
          tag = t_tag[idx[IDX_W-1:0]];
        end
      end
    end
  end

endmodule

// File: rtl/cas_post_pipe.sv
module cas_post_pipe #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned AL_W   = 3,
  parameter int unsigned CL_W   = 3,
  parameter int unsigned AL_MAX = 6,
  parameter int unsigned CL_MIN = 2,
  parameter int unsigned AL_RST = 0,
  parameter int unsigned CL_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic             cmd_wr,
  input  logic             cmd_bl8,
  input  logic [TAG_W-1:0] cmd_tag,
  input  logic             cfg_we,
  input  logic [AL_W-1:0]  cfg_al,
  input  logic [CL_W-1:0]  cfg_cl,
  output logic             icmd_vld,
  output logic             icmd_wr,
  output logic             icmd_bl8,
  output logic [TAG_W-1:0] icmd_tag,
  output logic             rd_win,
  output logic [TAG_W-1:0] rd_tag,
  output logic             wr_win,
  output logic [TAG_W-1:0] wr_tag,
  output logic             cfg_err
);

  localparam int unsigned CL_TOP = (1 << CL_W) - 1;
  localparam int unsigned DEPTH  = AL_MAX + CL_TOP + 3;
  localparam int unsigned IDX_W  = $clog2(DEPTH + 1);

  logic [AL_W-1:0]  al_cur;
  logic [CL_W-1:0]  cl_cur;
  logic             busy;
  logic             idle;
  logic [DEPTH:0]   t_vld;
  logic [DEPTH:0]   t_wr;
  logic [DEPTH:0]   t_bl8;
  logic [TAG_W-1:0] t_tag [0:DEPTH];
  logic [IDX_W-1:0] rl;
  logic [IDX_W-1:0] wl;

  assign idle = !cmd_vld && !busy;

  cpp_cfg #(
    .AL_W(AL_W), .CL_W(CL_W), .AL_MAX(AL_MAX), .CL_MIN(CL_MIN),
    .AL_RST(AL_RST), .CL_RST(CL_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_al(cfg_al),
    .cfg_cl(cfg_cl), .idle(idle), .al_q(al_cur), .cl_q(cl_cur),
    .err_q(cfg_err)
  );

  cpp_delay #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .in_vld(cmd_vld), .in_wr(cmd_wr),
    .in_bl8(cmd_bl8), .in_tag(cmd_tag), .t_vld(t_vld), .t_wr(t_wr),
    .t_bl8(t_bl8), .t_tag(t_tag), .busy(busy)
  );

  always_comb begin
    rl = IDX_W'(al_cur) + IDX_W'(cl_cur);
    wl = rl - IDX_W'(1);
  end

  // posted release: tap at the additive latency
  always_comb begin
    icmd_vld = t_vld[al_cur];
    icmd_wr  = t_wr[al_cur];
    icmd_bl8 = t_bl8[al_cur];
    icmd_tag = t_tag[al_cur];
  end

  cpp_win #(
    .TAG_W(TAG_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .KIND(cpp_pkg::KIND_RD)
  ) u_rdw (
    .t_vld(t_vld), .t_wr(t_wr), .t_bl8(t_bl8), .t_tag(t_tag),
    .base(rl), .win(rd_win), .tag(rd_tag)
  );

  cpp_win #(
    .TAG_W(TAG_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .KIND(cpp_pkg::KIND_WR)
  ) u_wrw (
    .t_vld(t_vld), .t_wr(t_wr), .t_bl8(t_bl8), .t_tag(t_tag),
    .base(wl), .win(wr_win), .tag(wr_tag)
  );

endmodule

// File: rtl/cpp_chk.sv
module cpp_chk #(
  parameter int unsigned AL_W   = 3,
  parameter int unsigned CL_W   = 3,
  parameter int unsigned AL_MAX = 6,
  parameter int unsigned CL_MIN = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_vld,
  input logic            cfg_we,
  input logic            icmd_vld,
  input logic            icmd_wr,
  input logic            rd_win,
  input logic            wr_win,
  input logic            cfg_err,
  input logic            busy,
  input logic [AL_W-1:0] al_cur,
  input logic [CL_W-1:0] cl_cur
);

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && al_cur == '0) |-> icmd_vld);

  assert_read_cl2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (icmd_vld && !icmd_wr && cl_cur == CL_W'(2)) |-> ##2 rd_win);

  assert_read_cl3_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (icmd_vld && !icmd_wr && cl_cur == CL_W'(3)) |-> ##3 rd_win);

  assert_write_cl2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (icmd_vld && icmd_wr && cl_cur == CL_W'(2)) |-> ##1 wr_win);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));

  assert_no_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(al_cur) <= AL_MAX) && (32'(cl_cur) >= CL_MIN));

  assert_frozen_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || cmd_vld) |=> ($stable(al_cur) && $stable(cl_cur)));

endmodule

bind cas_post_pipe cpp_chk #(
  .AL_W(AL_W), .CL_W(CL_W), .AL_MAX(AL_MAX), .CL_MIN(CL_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cfg_we(cfg_we),
  .icmd_vld(icmd_vld), .icmd_wr(icmd_wr), .rd_win(rd_win), .wr_win(wr_win),
  .cfg_err(cfg_err), .busy(busy), .al_cur(al_cur), .cl_cur(cl_cur)
);

// File: tb/sim_cas_post_pipe.sv
module sim_cas_post_pipe;

  localparam int TAG_W = 6;
  localparam int NCYC  = 4096;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_vld, cmd_wr, cmd_bl8;
  logic [TAG_W-1:0] cmd_tag;
  logic             cfg_we;
  logic [2:0]       cfg_al, cfg_cl;
  logic             icmd_vld, icmd_wr, icmd_bl8;
  logic [TAG_W-1:0] icmd_tag;
  logic             rd_win, wr_win, cfg_err;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  always #10 clk = ~clk;

  cas_post_pipe u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_bl8(cmd_bl8), .cmd_tag(cmd_tag), .cfg_we(cfg_we), .cfg_al(cfg_al),
    .cfg_cl(cfg_cl), .icmd_vld(icmd_vld), .icmd_wr(icmd_wr),
    .icmd_bl8(icmd_bl8), .icmd_tag(icmd_tag), .rd_win(rd_win),
    .rd_tag(rd_tag), .wr_win(wr_win), .wr_tag(wr_tag), .cfg_err(cfg_err)
  );

  typedef struct {
    int               at;
    bit               wr;
    bit               bl8;
    logic [TAG_W-1:0] tag;
    string            req;
  } ic_t;

  ic_t              icq[$];
  bit               exp_rd_v [NCYC];
  logic [TAG_W-1:0] exp_rd_t [NCYC];
  string            exp_rd_r [NCYC];
  bit               exp_wr_v [NCYC];
  logic [TAG_W-1:0] exp_wr_t [NCYC];
  string            exp_wr_r [NCYC];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int m_al = 0;
  int m_cl = 3;
  bit run_mon = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: compare every clock against the expected table and queue
  always @(negedge clk) begin
    int c;
    ic_t e;
    if (run_mon) begin
      c = cyc;
      if (exp_rd_v[c] || rd_win)
        chk((rd_win == exp_rd_v[c]) && (!rd_win || rd_tag == exp_rd_t[c]),
            exp_rd_v[c] ? exp_rd_r[c] : "R3", "rd_win/rd_tag",
            {25'd0, rd_win, rd_tag}, {25'd0, exp_rd_v[c], exp_rd_t[c]});
      if (exp_wr_v[c] || wr_win)
        chk((wr_win == exp_wr_v[c]) && (!wr_win || wr_tag == exp_wr_t[c]),
            exp_wr_v[c] ? exp_wr_r[c] : "R4", "wr_win/wr_tag",
            {25'd0, wr_win, wr_tag}, {25'd0, exp_wr_v[c], exp_wr_t[c]});
      if (icmd_vld) begin
        if (icq.size() == 0) chk(1'b0, "R2", "unexpected icmd", 1, 0);
        else begin
          e = icq.pop_front();
          chk(e.at == c, e.req, "icmd cycle", c, e.at);
          chk(icmd_wr == e.wr && icmd_bl8 == e.bl8 && icmd_tag == e.tag, e.req,
              "icmd fields", {23'd0, icmd_wr, icmd_bl8, icmd_tag}, {23'd0, e.wr, e.bl8, e.tag});
        end
      end else if (icq.size() > 0 && icq[0].at <= c) begin
        e = icq.pop_front();
        chk(1'b0, e.req, "missing icmd", c, e.at);
      end
    end
  end

  // driver: issue one command and record its expected effects
  task automatic issue(bit wr, bit bl8, logic [TAG_W-1:0] tag, string req);
    int k, s, n;
    ic_t e;
    @(posedge clk); #2;
    cfg_we  = 1'b0;
    k       = cyc;
    cmd_vld = 1'b1; cmd_wr = wr; cmd_bl8 = bl8; cmd_tag = tag;
    e.at = k + m_al; e.wr = wr; e.bl8 = bl8; e.tag = tag; e.req = req;
    icq.push_back(e);
    s = k + m_al + m_cl - (wr ? 1 : 0);
    n = bl8 ? 4 : 2;
    for (int o = 0; o < n; o++) begin
      if (wr) begin exp_wr_v[s+o] = 1'b1; exp_wr_t[s+o] = tag; exp_wr_r[s+o] = req; end
      else    begin exp_rd_v[s+o] = 1'b1; exp_rd_t[s+o] = tag; exp_rd_r[s+o] = req; end
    end
  endtask

  task automatic gap(int n);
    repeat (n) begin
      @(posedge clk); #2;
      cmd_vld = 1'b0;
      cfg_we  = 1'b0;
    end
  endtask

  task automatic cfg(bit [2:0] al, bit [2:0] cl, bit take, bit err, string req);
    @(posedge clk); #2;
    cmd_vld = 1'b0;
    cfg_we = 1'b1; cfg_al = al; cfg_cl = cl;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    @(negedge clk);
    chk(cfg_err == err, req, "cfg_err", int'(cfg_err), int'(err));
    @(negedge clk);
    chk(cfg_err == 1'b0, req, "cfg_err one clock", int'(cfg_err), 0);
    if (take) begin m_al = al; m_cl = cl; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_wr = 1'b0; cmd_bl8 = 1'b0; cmd_tag = '0;
    cfg_we = 1'b0; cfg_al = '0; cfg_cl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!icmd_vld, "R1", "icmd_vld at reset", int'(icmd_vld), 0);
    chk(!rd_win, "R1", "rd_win at reset", int'(rd_win), 0);
    chk(!wr_win, "R1", "wr_win at reset", int'(wr_win), 0);
    chk(!cfg_err, "R1", "cfg_err at reset", int'(cfg_err), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    run_mon = 1'b1;
    gap(2);

    // R1 default latencies, R2 same-clock release with AL=0
    issue(1'b0, 1'b0, 6'd1, "R1"); gap(1);
    issue(1'b1, 1'b0, 6'd2, "R2"); gap(24);

    // R9 legal setting, then R3/R4 with posted delay
    cfg(3'd2, 3'd4, 1'b1, 1'b0, "R9");
    issue(1'b0, 1'b0, 6'd3, "R3"); gap(5);
    issue(1'b1, 1'b0, 6'd4, "R4"); gap(5);
    issue(1'b0, 1'b1, 6'd5, "R3"); gap(5);
    issue(1'b1, 1'b1, 6'd6, "R4"); gap(24);

    // R5 seamless bursts
    issue(1'b0, 1'b0, 6'd7, "R5"); gap(1);
    issue(1'b0, 1'b0, 6'd8, "R5"); gap(1);
    issue(1'b0, 1'b1, 6'd9, "R5"); gap(3);
    issue(1'b0, 1'b1, 6'd10, "R5"); gap(24);
    issue(1'b1, 1'b0, 6'd11, "R5"); gap(1);
    issue(1'b1, 1'b0, 6'd12, "R5"); gap(24);

    // R6 truncated eight-element read
    issue(1'b0, 1'b1, 6'd13, "R6"); gap(1);
    issue(1'b0, 1'b1, 6'd14, "R6"); gap(24);

    // largest setting: deepest taps
    cfg(3'd6, 3'd7, 1'b1, 1'b0, "R9");
    issue(1'b0, 1'b1, 6'd15, "R3"); gap(3);
    issue(1'b1, 1'b1, 6'd16, "R4"); gap(24);

    // smallest write latency of one clock
    cfg(3'd0, 3'd2, 1'b1, 1'b0, "R9");
    issue(1'b1, 1'b0, 6'd17, "R4"); gap(1);
    issue(1'b0, 1'b0, 6'd18, "R3"); gap(24);

    // R7 reserved codes refused
    cfg(3'd7, 3'd3, 1'b0, 1'b1, "R7");
    cfg(3'd1, 3'd1, 1'b0, 1'b1, "R7");
    issue(1'b0, 1'b0, 6'd19, "R7"); gap(24);

    // R8 setting while a command is in flight
    issue(1'b0, 1'b0, 6'd20, "R8");
    cfg(3'd3, 3'd5, 1'b0, 1'b0, "R8");
    gap(24);
    issue(1'b0, 1'b0, 6'd21, "R8"); gap(24);

    chk(icq.size() == 0, "R2", "pending icmd at end", icq.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule